// File: doc/BRIEF.md
# DMA Channel Address and Count Tracker

This block keeps the per-transfer state of one DMA channel. The host loads a 16-bit starting memory address and a 16-bit count word before it enables the channel. The count word packs a 14-bit cycle count, programmed as the number of cycles minus one, with a 2-bit operation code above it. Each time the surrounding sequencer completes a DMA cycle it pulses `step`. The block then moves the address forward by one and takes one off the remaining count.

The block reports the operation code and flags an illegal one. It raises terminal count during the final cycle of the block. It raises a mark flag on every cycle that lies a whole multiple of 128 cycles before the end. The address leaves in split form. The low byte is on its own lines. The high byte is held on a shared-bus output, and a one-clock strobe tells an external latch to capture that byte each time it takes a new value.

Arbitration, host register decoding and read/write strobe generation belong to neighbouring blocks. The block is active while `chan_en` is high, the code is legal and the block is not finished.

Top module: `dma_chan_track`

## Requirements
- R1: After reset, `tc`, `mark`, `addr_stb` and `op_err` are 0, `addr_lo` and `addr_hi` are 0, and `op_kind` is 00.
- R2: `ld_addr` loads `ld_data` as the 16-bit address. `ld_cnt` loads `ld_data[13:0]` as the count and `ld_data[15:14]` as the operation code, and it starts a new block. `op_kind` shows the loaded code.
- R3: A `step` while the block is active adds one to the address, wrapping modulo 2^16. It also subtracts one from a non-zero count. Without `step` or `ld_addr`, `addr_lo` holds its value.
- R4: `tc` is 1 while the block is active and the count is 0. A `step` taken in that state ends the block. Later steps change nothing until the next `ld_cnt`.
- R5: `mark` is 1 while the block is active, the count is non-zero and the count's low 7 bits are 0. `tc` and `mark` are never 1 together.
- R6: Operation codes are 00 verify, 01 write (peripheral to memory) and 10 read (memory to peripheral). With code 11 and `chan_en` high, `op_err` is 1. The block is then inactive: steps do not move the address, `tc` and `mark` stay 0, and no strobe is issued.
- R7: While `chan_en` is 0, `tc` and `mark` are 0 and steps do not move the address.
- R8: `addr_lo` always shows the low byte of the current address.
- R9: `addr_stb` pulses for one clock in the cycle after the block is first seen active following a load. It also pulses in the cycle after the upper address byte changes. `addr_hi` changes only together with a strobe and shows the byte to latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable from the host setup |
| ld_addr | input | 1 | Load address from `ld_data` |
| ld_cnt | input | 1 | Load count and operation code from `ld_data` |
| ld_data | input | 16 | Load value |
| step | input | 1 | One DMA cycle completed |
| addr_lo | output | 8 | Low address byte, dedicated lines |
| addr_hi | output | 8 | Upper address byte for the shared bus |
| addr_stb | output | 1 | Capture strobe for the upper byte |
| op_kind | output | 2 | Loaded operation code |
| op_err | output | 1 | Illegal operation code while enabled |
| tc | output | 1 | Last cycle of the block |
| mark | output | 1 | Cycle a multiple of 128 before the end |

## Verification
The bench starts transfers near a 256-byte boundary. A design that strobes only on the first cycle, or compares the wrong byte, would miss the second upper-byte strobe or report a stale latched value. A 300-cycle block checks that mark appears exactly at remaining counts 256 and 128 and never together with terminal count; an off-by-one mark would land one step early or late. A count of zero checks that terminal count appears on the first and only cycle. Extra steps after the end, steps while disabled and steps under the illegal code must leave the address where it was; a tracker that kept counting would move `addr_lo`.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    OP_VERIFY  = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ILLEGAL = 2'b11
  } op_kind_e;
endpackage

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit #(
  parameter int CNT_W    = 14,
  parameter int OP_W     = 2,
  parameter int MARK_LOG = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  chan_en,
  input  logic                  ld_cnt,
  input  logic [CNT_W+OP_W-1:0] ld_word,
  input  logic                  step,
  output logic                  active,
  output logic [OP_W-1:0]       op_q,
  output logic                  op_err,
  output logic                  tc,
  output logic                  mark
);
  import dma_chan_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             illegal;
  logic             cnt_zero;

  assign illegal  = (op_q == OP_ILLEGAL);
  assign cnt_zero = (cnt_q == '0);
  assign active   = chan_en && !done_q && !illegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      op_q   <= OP_VERIFY;
      done_q <= 1'b1;
    end else if (ld_cnt) begin
      cnt_q  <= ld_word[CNT_W-1:0];
      op_q   <= ld_word[CNT_W+OP_W-1:CNT_W];
      done_q <= 1'b0;
    end else if (step && active) begin
      if (cnt_zero) done_q <= 1'b1;
      else          cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign op_err = chan_en && illegal;
  assign tc     = active && cnt_zero;
  assign mark   = active && !cnt_zero && (cnt_q[MARK_LOG-1:0] == '0);
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_addr,
  input  logic              ld_any,
  input  logic [ADDR_W-1:0] ld_word,
  input  logic              active,
  input  logic              step,
  output logic [LO_W-1:0]        addr_lo,
  output logic [ADDR_W-LO_W-1:0] addr_hi,
  output logic                   addr_stb
);
  localparam int HI_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] addr_q;
  logic [HI_W-1:0]   hi_seen_q;
  logic              hi_valid_q;
  logic              stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (ld_addr) begin
      addr_q <= ld_word;
    end else if (step && active) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_seen_q  <= '0;
      hi_valid_q <= 1'b0;
      stb_q      <= 1'b0;
    end else if (ld_any) begin
      hi_valid_q <= 1'b0;
      stb_q      <= 1'b0;
    end else if (active && (!hi_valid_q || hi_seen_q != addr_q[ADDR_W-1:LO_W])) begin
      hi_seen_q  <= addr_q[ADDR_W-1:LO_W];
      hi_valid_q <= 1'b1;
      stb_q      <= 1'b1;
    end else begin
      stb_q      <= 1'b0;
    end
  end

  assign addr_lo  = addr_q[LO_W-1:0];
  assign addr_hi  = hi_seen_q;
  assign addr_stb = stb_q;
endmodule

// File: rtl/dma_chan_track.sv
module dma_chan_track #(
  parameter int ADDR_W   = 16,
  parameter int LO_W     = 8,
  parameter int CNT_W    = 14,
  parameter int OP_W     = 2,
  parameter int MARK_LOG = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     chan_en,
  input  logic                     ld_addr,
  input  logic                     ld_cnt,
  input  logic [ADDR_W-1:0]        ld_data,
  input  logic                     step,
  output logic [LO_W-1:0]          addr_lo,
  output logic [ADDR_W-LO_W-1:0]   addr_hi,
  output logic                     addr_stb,
  output logic [OP_W-1:0]          op_kind,
  output logic                     op_err,
  output logic                     tc,
  output logic                     mark
);
  localparam int WORD_W = CNT_W + OP_W;

  logic active;

  dma_cnt_unit #(.CNT_W(CNT_W), .OP_W(OP_W), .MARK_LOG(MARK_LOG)) cnt_i (
    .clk(clk), .rst(rst), .chan_en(chan_en), .ld_cnt(ld_cnt),
    .ld_word(ld_data[WORD_W-1:0]), .step(step), .active(active),
    .op_q(op_kind), .op_err(op_err), .tc(tc), .mark(mark)
  );

  dma_addr_unit #(.ADDR_W(ADDR_W), .LO_W(LO_W)) addr_i (
    .clk(clk), .rst(rst), .ld_addr(ld_addr), .ld_any(ld_addr || ld_cnt),
    .ld_word(ld_data), .active(active), .step(step),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .addr_stb(addr_stb)
  );
endmodule

// File: rtl/dma_chan_track_chk.sv
module dma_chan_track_chk (
  input logic       clk,
  input logic       rst,
  input logic       chan_en,
  input logic       ld_addr,
  input logic       step,
  input logic [7:0] addr_lo,
  input logic [7:0] addr_hi,
  input logic       addr_stb,
  input logic       op_err,
  input logic       tc,
  input logic       mark
);
  AST_TC_MARK_EXCL: assert property (@(posedge clk) disable iff (rst) !(tc && mark)); // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst) op_err |-> (!tc && !mark)); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) !chan_en |-> (!tc && !mark)); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) (!step && !ld_addr) |=> $stable(addr_lo)); // R3
  AST_HI_WITH_STB: assert property (@(posedge clk) disable iff (rst) !addr_stb |-> $stable(addr_hi)); // R9
endmodule

bind dma_chan_track dma_chan_track_chk chk_i (
  .clk(clk), .rst(rst), .chan_en(chan_en), .ld_addr(ld_addr), .step(step),
  .addr_lo(addr_lo), .addr_hi(addr_hi), .addr_stb(addr_stb),
  .op_err(op_err), .tc(tc), .mark(mark)
);

// File: tb/dma_chan_track_tb_top.sv
module dma_chan_track_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chan_en = 1'b0, ld_addr = 1'b0, ld_cnt = 1'b0, step = 1'b0;
  logic [15:0] ld_data = '0;
  logic [7:0]  addr_lo, addr_hi;
  logic        addr_stb, op_err, tc, mark;
  logic [1:0]  op_kind;

  int checks = 0, errors = 0;
  int stb_n = 0;
  logic [7:0] last_hi = '0;

  typedef struct packed { logic [15:0] a; logic t; logic m; } exp_t;
  exp_t q[$];

  logic [15:0] m_addr;
  logic [13:0] m_cnt;
  bit          m_live;

  always #5 clk = ~clk;

  dma_chan_track dut_i (
    .clk(clk), .rst(rst), .chan_en(chan_en), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .ld_data(ld_data), .step(step), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .addr_stb(addr_stb), .op_kind(op_kind), .op_err(op_err), .tc(tc), .mark(mark)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (!rst && addr_stb) begin
    stb_n++;
    last_hi = addr_hi;
  end

  // monitor: compare outputs of each stepped cycle with the queued expectation
  always @(negedge clk) begin
    #2;
    if (step && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R8 addr_lo", addr_lo, e.a[7:0]);
      chk("R4 tc", tc, e.t);
      chk("R5 mark", mark, e.m);
    end
  end

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk); ld_addr = 1'b1; ld_data = a;
    @(negedge clk); ld_addr = 1'b0; ld_cnt = 1'b1; ld_data = c;
    @(negedge clk); ld_cnt = 1'b0;
    m_addr = a; m_cnt = c[13:0]; m_live = (c[15:14] != 2'b11);
  endtask

  // driver: one step, pushing what the requirements predict for that cycle
  task automatic do_step(input bit en);
    @(negedge clk);
    if (m_live && en) begin
      exp_t e;
      e.a = m_addr; e.t = (m_cnt == 0); e.m = (m_cnt != 0) && (m_cnt[6:0] == 0);
      q.push_back(e);
      m_addr = m_addr + 1;
      if (m_cnt == 0) m_live = 0; else m_cnt = m_cnt - 1;
    end
    step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, marks;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk("R1 tc", tc, 0); chk("R1 mark", mark, 0); chk("R1 stb", addr_stb, 0);
    chk("R1 op_err", op_err, 0); chk("R1 addr", {addr_hi, addr_lo}, 0); chk("R1 op", op_kind, 0);

    // R2 R3 R9: write transfer of 4 bytes across a page boundary
    load(16'h12FE, 16'h4003);
    #1 chk("R2 op_kind", op_kind, 2'b01);
    chk("R2 addr_lo", addr_lo, 8'hFE);
    chan_en = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk("R9 first strobe", stb_n, 1); chk("R9 first hi", last_hi, 8'h12);
    for (int i = 0; i < 4; i++) do_step(1);
    repeat (3) @(negedge clk);
    #1 chk("R9 page strobe", stb_n, 2); chk("R9 page hi", last_hi, 8'h13);
    chk("R9 addr_hi", addr_hi, 8'h13);
    // R4: block ended, extra steps ignored
    do_step(1); do_step(1);
    #1 chk("R4 addr after end", addr_lo, 8'h02); chk("R4 tc after end", tc, 0);

    // R5: 300-cycle read, marks at counts 256 and 128
    load(16'h20F0, 16'h8000 | 16'd299);
    #1 chk("R2 op read", op_kind, 2'b10);
    s0 = stb_n; marks = 0;
    for (int i = 0; i < 300; i++) begin
      do_step(1);
    end
    repeat (3) @(negedge clk);
    #1 chk("R9 strobes 300", stb_n - s0, 3); chk("R3 addr wrap lo", addr_lo, 8'h1C);
    chk("R9 last hi", last_hi, 8'h22);

    // R4: single-cycle block (count 0), verify code
    load(16'h0500, 16'h0000);
    #1 chk("R2 op verify", op_kind, 2'b00); chk("R4 tc immediate", tc, 1); chk("R5 no mark", mark, 0);
    do_step(1);
    #1 chk("R4 tc drops", tc, 0);

    // R6: illegal code
    load(16'h3340, 16'hC005);
    #1 s0 = stb_n;
    chk("R6 op_err", op_err, 1); chk("R6 op_kind", op_kind, 2'b11); chk("R6 tc", tc, 0);
    do_step(1); do_step(1);
    #1 chk("R6 addr held", addr_lo, 8'h40); chk("R6 no strobe", stb_n - s0, 0);

    // R7: disabled channel
    chan_en = 1'b0;
    load(16'h4480, 16'h4005);
    #1 chk("R7 tc", tc, 0); chk("R6 op_err off", op_err, 0);
    do_step(0); do_step(0);
    #1 chk("R7 addr held", addr_lo, 8'h80);
    chan_en = 1'b1;
    do_step(1);
    #1 chk("R7 resumes", addr_lo, 8'h81);

    repeat (4) @(negedge clk);
    chk("R8 queue drained", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule